// File: doc/BRIEF.md
# Reloadable Lookup-Table Logic Element

This block is a single programmable logic element of the kind tiled across a reconfigurable fabric. A small volatile store holds the truth table of an arbitrary Boolean function of `NUM_IN` select inputs (four by default, giving a 16-entry table). The select inputs index the table, and the indexed bit is the combinational result. A mode bit chooses what drives the output: either that result directly, or a D flip-flop that captures it on each rising clock edge.

The table and the mode bit arrive over a one-bit serial configuration port, one bit per clock while the configuration enable is high, as a host or boot memory would deliver them. Reset models power-up. It wipes the table, the mode and the configured flag, so the element stays unconfigured with its output forced low until a complete image has been shifted in again. Loading a fresh image at any time turns the element into a different function.

Top module: `lut_cell`

## Requirements
- R1: While reset is asserted and just after it is released, `cfg_done` is 0 and `cell_out` is 0.
- R2: Configuration bits are taken least significant first. The first accepted bit becomes table entry 0, and so on up to the 16th, which becomes entry 15. The 17th accepted bit is the mode: 0 selects combinational output, 1 selects registered output.
- R3: `cfg_done` becomes 1 after the rising edge that accepts the 17th bit of a load, and is 0 before it.
- R4: Whenever `cfg_done` is 0, `cell_out` is 0 for every value of `sel_in`.
- R5: In combinational mode with `cfg_done` at 1, `cell_out` equals table entry `sel_in` in the same cycle.
- R6: In registered mode, `cell_out` equals the table entry that `sel_in` selected at the previous rising edge. An edge at which `cfg_done` was 0 loads 0 into the register.
- R7: A bit accepted while `cfg_done` is 1 begins a new load. That bit becomes entry 0, and `cfg_done` drops to 0 until 17 bits of the new load have been accepted.
- R8: While `cfg_enable` is 0, `cfg_bit` is ignored: the table, the mode and `cfg_done` keep their values. A load may pause this way mid-image and resume where it stopped.
- R9: Reloading a configured element with a different image makes it implement the new function and mode.
- R10: A reset after configuration returns the element to the unconfigured state, with output 0 even where the old table held 1. It works again only after a full reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| cfg_enable | input | 1 | Accept `cfg_bit` on this rising edge |
| cfg_bit | input | 1 | Serial configuration data, least significant first |
| sel_in | input | NUM_IN | Logic inputs that index the truth table |
| cell_out | output | 1 | Element output, 0 while unconfigured |
| cfg_done | output | 1 | A complete image is loaded |

## Verification
The assertions assume that `cfg_enable`, `cfg_bit` and `sel_in` are known, non-X values that change only between clock edges. They also assume that the registered-mode comparison begins only once a full edge has passed with the element configured. The bench meets these assumptions by driving every input on the falling clock edge from tasks and never leaving an input undriven after time zero. It samples the outputs just after that falling edge, so the registered output reflects exactly one rising edge per step.

// File: rtl/lut_cell_pkg.sv
// Package: shared types for the lookup-table logic element.
// Assumes: nothing beyond IEEE 1800-2017.
package lut_cell_pkg;

    // Output source selected by the final configuration bit.
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

endpackage

// File: rtl/lut_cfg_shift.sv
// Module: serial configuration loader. Shifts the image in least significant
// bit first and counts accepted bits. Once the full image is in, the count
// sits at its limit and the element is configured. Any later accepted bit
// restarts the count.
// Assumes: cfg_en and cfg_bit are synchronous to clk.
module lut_cfg_shift
    import lut_cell_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_en,
    input  logic                         cfg_bit,
    output logic [(1 << NUM_IN)-1:0]     table_o,
    output out_mode_e                    mode_o,
    output logic                         done_o
);
    localparam int TBL_BITS = 1 << NUM_IN;
    localparam int CFG_BITS = TBL_BITS + 1;
    localparam int CW       = $clog2(CFG_BITS + 1);

    logic [CFG_BITS-1:0] img_q;
    logic [CW-1:0]       cnt_q;
    logic                full;

    // Purpose: the image is complete once the count reaches its limit.
    always_comb full = (cnt_q == CW'(CFG_BITS));

    // Purpose: shift in accepted bits and count them, restarting after a full image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q <= '0;
            cnt_q <= '0;
        end else if (cfg_en) begin
            img_q <= {cfg_bit, img_q[CFG_BITS-1:1]};
            cnt_q <= full ? CW'(1) : cnt_q + CW'(1);
        end
    end

    assign table_o = img_q[TBL_BITS-1:0];
    assign mode_o  = out_mode_e'(img_q[CFG_BITS-1]);
    assign done_o  = full;

endmodule

// File: rtl/lut_read.sv
// Module: truth-table read port. Selects one table bit using the logic inputs.
// Assumes: the table is held stable by the loader outside configuration.
module lut_read #(
    parameter int NUM_IN = 4
) (
    input  logic [(1 << NUM_IN)-1:0] table_i,
    input  logic [NUM_IN-1:0]        sel_i,
    output logic                     bit_o
);
    // Purpose: index the stored function with the logic inputs.
    always_comb bit_o = table_i[sel_i];

endmodule

// File: rtl/lut_out_stage.sv
// Module: output stage. Holds the capture flip-flop and picks the combinational
// or the registered value. Forces 0 while the element is unconfigured.
// Assumes: mode is meaningful only while done is high.
module lut_out_stage
    import lut_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lut_bit,
    input  out_mode_e mode,
    input  logic      done,
    output logic      out_o
);
    logic cap_q;

    // Purpose: capture the table output each edge; load 0 while unconfigured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
        end else begin
            cap_q <= done & lut_bit;
        end
    end

    // Purpose: choose the output source and gate it with the configured flag.
    always_comb begin
        if (!done) begin
            out_o = 1'b0;
        end else if (mode == OUT_REG) begin
            out_o = cap_q;
        end else begin
            out_o = lut_bit;
        end
    end

endmodule

// File: rtl/lut_cell.sv
// Module: top of the reloadable lookup-table logic element. Ties together the
// serial loader, the table read port and the output stage.
// Assumes: reset models power-up and is applied before use.
module lut_cell
    import lut_cell_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_bit,
    input  logic [NUM_IN-1:0] sel_in,
    output logic              cell_out,
    output logic              cfg_done
);
    localparam int TBL_BITS = 1 << NUM_IN;

    logic [TBL_BITS-1:0] cfg_table;
    out_mode_e           cfg_mode;
    logic                lut_val;

    lut_cfg_shift #(.NUM_IN(NUM_IN)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_enable),
        .cfg_bit (cfg_bit),
        .table_o (cfg_table),
        .mode_o  (cfg_mode),
        .done_o  (cfg_done)
    );

    lut_read #(.NUM_IN(NUM_IN)) u_read (
        .table_i (cfg_table),
        .sel_i   (sel_in),
        .bit_o   (lut_val)
    );

    lut_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .lut_bit (lut_val),
        .mode    (cfg_mode),
        .done    (cfg_done),
        .out_o   (cell_out)
    );

endmodule

// File: rtl/lut_cell_chk.sv
// Module: assertion checker for lut_cell, attached with bind below.
// Assumes: inputs are known values that change between clock edges.
module lut_cell_chk #(
    parameter int NUM_IN = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_enable,
    input logic                     cfg_done,
    input logic                     cell_out,
    input logic                     mode,
    input logic                     lut_bit,
    input logic [(1 << NUM_IN)-1:0] tbl
);
    AST_UNCONF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> !cell_out); // R4

    AST_DONE_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(cfg_enable)); // R3

    AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && cfg_enable) |=> !cfg_done); // R7

    AST_IDLE_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> $stable(cfg_done)); // R8

    AST_IDLE_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> $stable(tbl)); // R8

    AST_COMB_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && !mode) |-> (cell_out == lut_bit)); // R5

    AST_REG_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && mode && $past(cfg_done)) |-> (cell_out == $past(lut_bit))); // R6

endmodule

bind lut_cell lut_cell_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_done   (cfg_done),
    .cell_out   (cell_out),
    .mode       (cfg_mode),
    .lut_bit    (lut_val),
    .tbl        (cfg_table)
);

// File: tb/test_lut_cell.sv
// Bench: directed scenarios for lut_cell, one task each, self-checking.
module test_lut_cell;
    localparam int NUM_IN   = 4;
    localparam int TBL_BITS = 1 << NUM_IN;
    localparam int CFG_BITS = TBL_BITS + 1;

    localparam logic [15:0] TBL_A = 16'hA5C3;
    localparam logic [15:0] TBL_B = 16'h6996;
    localparam logic [15:0] TBL_C = 16'h8421;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_enable = 1'b0;
    logic              cfg_bit = 1'b0;
    logic [NUM_IN-1:0] sel_in = '0;
    logic              cell_out;
    logic              cfg_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lut_cell #(.NUM_IN(NUM_IN)) i_lut_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_enable (cfg_enable),
        .cfg_bit    (cfg_bit),
        .sel_in     (sel_in),
        .cell_out   (cell_out),
        .cfg_done   (cfg_done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_enable = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Shift one image in; pause_at >= 0 inserts four idle cycles after that many bits.
    task automatic load_img(input logic [CFG_BITS-1:0] img, input int pause_at);
        for (int i = 0; i < CFG_BITS; i++) begin
            if (i == pause_at) begin
                for (int p = 0; p < 4; p++) begin
                    @(negedge clk);
                    cfg_enable = 1'b0;
                    cfg_bit = p[0];
                end
                #1;
                check(cfg_done == 1'b0, "R8 paused load stays unconfigured", cfg_done, 0);
            end
            @(negedge clk);
            cfg_enable = 1'b1;
            cfg_bit = img[i];
        end
        @(negedge clk);
        cfg_enable = 1'b0;
        #1;
        check(cfg_done == 1'b1, "R3 done after 17th bit", cfg_done, 1);
    endtask

    task automatic sweep_comb(input logic [15:0] tbl, input string req);
        for (int s = 0; s < TBL_BITS; s++) begin
            @(negedge clk);
            sel_in = s[NUM_IN-1:0];
            #1;
            check(cell_out == tbl[s], req, cell_out, tbl[s]);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(cfg_done == 1'b0 && cell_out == 1'b0, "R1 during reset", {cfg_done, cell_out}, 0);
        rst_n = 1'b1;
        for (int s = 0; s < TBL_BITS; s += 5) begin
            @(negedge clk);
            sel_in = s[NUM_IN-1:0];
            #1;
            check(cell_out == 1'b0, "R4 unconfigured output low", cell_out, 0);
        end
        check(cfg_done == 1'b0, "R1 flag low after reset", cfg_done, 0);
    endtask

    task automatic t_comb();
        load_img({1'b0, TBL_A}, -1);
        sweep_comb(TBL_A, "R2 R5 combinational table A");
    endtask

    task automatic t_idle();
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            cfg_enable = 1'b0;
            cfg_bit = ~c[0];
            sel_in = c[NUM_IN-1:0];
        end
        #1;
        check(cfg_done == 1'b1, "R8 flag kept while idle", cfg_done, 1);
        sweep_comb(TBL_A, "R8 table kept while idle");
    endtask

    task automatic t_reload();
        logic [CFG_BITS-1:0] img;
        img = {1'b1, TBL_B};
        @(negedge clk);
        sel_in = 4'd1;
        cfg_enable = 1'b1;
        cfg_bit = img[0];
        @(negedge clk);
        #1;
        check(cfg_done == 1'b0, "R7 flag drops on new load", cfg_done, 0);
        check(cell_out == 1'b0, "R4 output low during reload", cell_out, 0);
        for (int i = 1; i < CFG_BITS; i++) begin
            cfg_bit = img[i];
            if (i < CFG_BITS - 1) begin
                @(negedge clk);
                #1;
                check(cfg_done == 1'b0, "R7 flag low mid-load", cfg_done, 0);
            end
        end
        @(negedge clk);
        cfg_enable = 1'b0;
        #1;
        check(cfg_done == 1'b1, "R3 done after reload", cfg_done, 1);
        check(cell_out == 1'b0, "R6 register loaded 0 while unconfigured", cell_out, 0);
        @(negedge clk);
        #1;
        check(cell_out == TBL_B[1], "R6 R9 registered entry 1", cell_out, TBL_B[1]);
        for (int s = 0; s < TBL_BITS; s += 3) begin
            @(negedge clk);
            sel_in = s[NUM_IN-1:0];
            #1;
            check(cell_out == TBL_B[(s + TBL_BITS - 3) % TBL_BITS] || s == 0,
                  "R6 output holds previous capture", cell_out,
                  TBL_B[(s + TBL_BITS - 3) % TBL_BITS]);
            @(negedge clk);
            #1;
            check(cell_out == TBL_B[s], "R6 R9 registered table B", cell_out, TBL_B[s]);
        end
    endtask

    task automatic t_power_cycle();
        @(negedge clk);
        sel_in = 4'd1;
        do_reset();
        #1;
        check(cfg_done == 1'b0, "R10 flag cleared by reset", cfg_done, 0);
        check(cell_out == 1'b0, "R10 output low after reset", cell_out, 0);
        repeat (2) @(negedge clk);
        #1;
        check(cell_out == 1'b0, "R10 stays low without reload", cell_out, 0);
        load_img({1'b0, TBL_C}, 8);
        sweep_comb(TBL_C, "R8 R10 paused reload table C");
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_comb();
        t_idle();
        t_reload();
        t_power_cycle();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule